// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller that sits beside a 10-bit successive-approximation converter. A small register port lets software choose an input channel, pick a clock divide ratio, and start one conversion or let conversions run back to back. The block divides the system clock to pace each conversion. It pulses a start strobe toward the converter and drives the channel number. At the end of the conversion it captures the 10-bit result.

The channel register is a shadow. Its value reaches the converter only when a conversion begins, so software can queue the next channel while the current one runs. The result is presented as two bytes, right- or left-justified. Reading the low byte freezes both bytes until the high byte is read, so a new result can never mix with the old one.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion lasts 13 converter clocks. Each converter clock is D system cycles, where D is set by control bits 2:0: codes 0 and 1 give D=2, and code k≥2 gives D=2^k. The flag sets 13·D cycles after the cycle in which `conv_start` is high.
- R2: Address 2 is the low byte and address 3 is the high byte. With mux bit 7 (left-justify) clear, which is its reset state, the low byte holds result bits 7:0 and the high byte holds bits 9:8 in its bits 1:0, with zeros above.
- R3: With left-justify set, the high byte holds result bits 9:2 and the low byte holds bits 1:0 in its bits 7:6, with zeros below.
- R4: A read of address 2 locks the result. The lock holds until address 3 is read. A conversion that completes while the result is locked, or in the same cycle as the low-byte read, is discarded, but the flag still sets.
- R5: Both result bytes reset to zero. Writes to addresses 2 and 3 have no effect.
- R6: Address 0 holds the channel in bits 3:0 and left-justify in bit 7. `conv_chan` changes only in the cycle where `conv_start` is high, and it then takes the shadow value. A mid-conversion write does not alter the running conversion.
- R7: Setting control bits 7 (enable) and 5 (repeat) makes conversions run back to back. Each new conversion starts at the same clock edge that sets the flag. A channel write made after that edge is used by the conversion after next.
- R8: Writing control with bits 7 and 6 set while idle starts exactly one conversion. Control bit 6 reads 1 while a conversion is running and 0 once it is done.
- R9: Control bit 4 is the done flag. Writing 1 to it clears it, and completion sets it with priority over the clear. `irq` equals the flag ANDed with control bit 3.
- R10: `conv_start` is a single-cycle pulse, and it occurs only for conversions that were requested. Clearing enable stops all further conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on result bytes) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| conv_start | output | 1 | Start pulse to converter |
| conv_chan | output | CH_W | Channel applied to the converter |
| conv_result | input | 10 | Converter result, sampled at the last converter clock |
| irq | output | 1 | Completion interrupt |

## Verification
The bench times conversions at the fastest divide, the slowest divide and the two codes that share divide-by-2. A prescaler that counts one cycle short or long, or that decodes code 1 as divide-by-1, shows up as a wrong cycle count. It locks the result with a low-byte read and lets a new conversion finish. A design that overwrote the locked pair would return a mixed high byte, and one that suppressed the flag would miss the completion. In back-to-back mode it rewrites the channel both before and after a completion edge. An unshadowed mux would change the channel in the middle of a conversion, and a restart one cycle late would break the 26-cycle spacing and the same-edge rise of the interrupt.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W     = 4,
  parameter int CONV_CYC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  input  logic [9:0]      conv_result,
  output logic            irq
);
  localparam int CYC_W = $clog2(CONV_CYC + 1);

  logic [6:0]       mux_q;
  logic             adj_q, en_q, free_q, ie_q, flag_q, busy_q, lock_q;
  logic [2:0]       ps_q;
  logic [6:0]       pcnt_q;
  logic [CYC_W-1:0] acyc_q;
  logic [9:0]       res_q;

  wire wr_mux = bus_wr && bus_addr == 2'd0;
  wire wr_ctl = bus_wr && bus_addr == 2'd1;
  wire rd_lo  = bus_rd && bus_addr == 2'd2;
  wire rd_hi  = bus_rd && bus_addr == 2'd3;

  wire       en_nx   = wr_ctl ? bus_wdata[7] : en_q;
  wire       free_nx = wr_ctl ? bus_wdata[5] : free_q;
  wire [6:0] ps_mask = (ps_q[2:1] == 2'b00) ? 7'h01 : 7'((8'd1 << ps_q) - 8'd1);
  wire       tick    = busy_q && ((pcnt_q & ps_mask) == ps_mask);
  wire       finish  = tick && (acyc_q == CYC_W'(CONV_CYC - 1));
  wire       go      = en_nx && ((free_nx && (!busy_q || finish)) ||
                                 (wr_ctl && bus_wdata[6] && !busy_q));
  wire       store   = finish && !lock_q && !rd_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0; adj_q <= 1'b0;
      en_q <= 1'b0; free_q <= 1'b0; ie_q <= 1'b0; ps_q <= '0;
      flag_q <= 1'b0; busy_q <= 1'b0; lock_q <= 1'b0;
      pcnt_q <= '0; acyc_q <= '0; res_q <= '0;
      conv_start <= 1'b0; conv_chan <= '0;
    end else begin
      if (wr_mux) begin
        mux_q <= bus_wdata[6:0];
        adj_q <= bus_wdata[7];
      end
      if (wr_ctl) begin
        en_q   <= bus_wdata[7];
        free_q <= bus_wdata[5];
        ie_q   <= bus_wdata[3];
        ps_q   <= bus_wdata[2:0];
      end
      conv_start <= go;
      if (!en_nx) begin
        busy_q <= 1'b0;
      end else if (go) begin
        busy_q    <= 1'b1;
        pcnt_q    <= '0;
        acyc_q    <= '0;
        conv_chan <= mux_q[CH_W-1:0];
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        pcnt_q <= pcnt_q + 7'd1;
        if (tick) acyc_q <= acyc_q + 1'b1;
      end
      if (finish) flag_q <= 1'b1;
      else if (wr_ctl && bus_wdata[4]) flag_q <= 1'b0;
      if (store) res_q <= conv_result;
      if (rd_lo) lock_q <= 1'b1;
      else if (rd_hi) lock_q <= 1'b0;
    end
  end

  wire [7:0] lo_byte = adj_q ? {res_q[1:0], 6'b0} : res_q[7:0];
  wire [7:0] hi_byte = adj_q ? res_q[9:2] : {6'b0, res_q[9:8]};

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {adj_q, mux_q};
      2'd1:    bus_rdata = {en_q, busy_q, free_q, flag_q, ie_q, ps_q};
      2'd2:    bus_rdata = lo_byte;
      default: bus_rdata = hi_byte;
    endcase
  end

  assign irq = flag_q & ie_q;

  a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_hi) |=> $stable(res_q));
  a_r6_chan_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |-> $stable(conv_chan));
  a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && en_q && free_q && !wr_ctl) |=> conv_start);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r9_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> flag_q);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       conv_start, irq;
  logic [3:0] conv_chan;
  logic [9:0] conv_result = '0;

  adc_seq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_result(conv_result), .irq(irq));

  always #2 clk = ~clk;

  typedef struct packed { logic [3:0] ch; logic [31:0] gap; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0, last_start = 0;
  logic [7:0] d;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (q.size() == 0) chk(0, "R10 unrequested start", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(conv_chan == e.ch, "R6 channel at start", conv_chan, e.ch);
        if (e.gap != 0) chk(cyc - last_start == e.gap, "R7 restart spacing", cyc - last_start, e.gap);
      end
      last_start = cyc;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic run_single(input logic [2:0] ps, input logic [3:0] ch, input logic [9:0] res);
    int div;
    div = (ps < 2) ? 2 : (1 << ps);
    wr(2'd0, {4'h0, ch});
    conv_result = res;
    q.push_back('{ch: ch, gap: 0});
    wr(2'd1, 8'hD8 | {5'b0, ps});
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
    chk(cyc - last_start == 13 * div, "R1 conversion length", cyc - last_start, 13 * div);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic prev;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(conv_start == 0 && irq == 0, "R10 reset outputs", {conv_start, irq}, 0);
    rd(2'd1, d); chk(d == 8'h00, "R9 reset control", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R5 reset low", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R5 reset high", d, 0);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd2, d); chk(d == 8'h00, "R5 low write ignored", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R5 high write ignored", d, 0);

    wr(2'd0, 8'h05);
    conv_result = 10'h2A5;
    q.push_back('{ch: 4'd5, gap: 0});
    wr(2'd1, 8'hC8);
    rd(2'd1, d); chk(d[6] == 1'b1, "R8 start bit busy", d[6], 1);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    chk(cyc - last_start == 26, "R1 code 0 length", cyc - last_start, 26);
    rd(2'd1, d); chk(d[6] == 1'b0, "R8 start bit cleared", d[6], 0);
    rd(2'd2, d); chk(d == 8'hA5, "R2 right low", d, 8'hA5);
    rd(2'd3, d); chk(d == 8'h02, "R2 right high", d, 8'h02);
    wr(2'd1, 8'h98);
    chk(irq == 0, "R9 irq after clear", irq, 0);
    rd(2'd1, d); chk(d[4] == 1'b0, "R9 flag cleared", d[4], 0);
    repeat (60) @(negedge clk);
    rd(2'd1, d); chk(d[4] == 1'b0 && q.size() == 0, "R8 only one conversion", d[4], 0);

    wr(2'd0, 8'h82);
    rd(2'd2, d); chk(d == 8'h40, "R3 left low", d, 8'h40);
    rd(2'd3, d); chk(d == 8'hA9, "R3 left high", d, 8'hA9);
    rd(2'd0, d); chk(d == 8'h82, "R6 mux readback", d, 8'h82);

    run_single(3'd1, 4'd3, 10'h3FF);
    rd(2'd2, d); chk(d == 8'hFF, "R2 low all ones", d, 8'hFF);
    rd(2'd3, d); chk(d == 8'h03, "R2 high all ones", d, 8'h03);
    run_single(3'd3, 4'd4, 10'h155);
    run_single(3'd7, 4'd6, 10'h0AA);
    rd(2'd2, d); chk(d == 8'hAA, "R2 low after div128", d, 8'hAA);
    rd(2'd3, d);

    run_single(3'd0, 4'd1, 10'h111);
    rd(2'd2, d); chk(d == 8'h11, "R4 first low", d, 8'h11);
    run_single(3'd0, 4'd1, 10'h3CC);
    rd(2'd1, d); chk(d[4] == 1'b1, "R4 flag set while locked", d[4], 1);
    rd(2'd3, d); chk(d == 8'h01, "R4 locked high kept", d, 8'h01);
    rd(2'd2, d); chk(d == 8'h11, "R4 result dropped", d, 8'h11);
    rd(2'd3, d);
    run_single(3'd0, 4'd1, 10'h3CC);
    rd(2'd2, d); chk(d == 8'hCC, "R4 unlocked low", d, 8'hCC);
    rd(2'd3, d); chk(d == 8'h03, "R4 unlocked high", d, 8'h03);

    wr(2'd1, 8'h10);
    wr(2'd0, 8'h01);
    q.push_back('{ch: 4'd1, gap: 0});
    q.push_back('{ch: 4'd2, gap: 26});
    q.push_back('{ch: 4'd3, gap: 26});
    wr(2'd1, 8'hA8);
    wr(2'd0, 8'h02);
    chk(conv_chan == 4'd1, "R6 mid-conversion write held", conv_chan, 1);
    prev = irq;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (conv_start) break;
      prev = irq;
    end
    chk(irq == 1 && prev == 0, "R7 restart on flag edge", {prev, irq}, 1);
    wr(2'd0, 8'h03);
    chk(conv_chan == 4'd2, "R7 late write not applied", conv_chan, 2);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (conv_start) break;
    end
    wr(2'd1, 8'h10);
    repeat (80) @(negedge clk);
    chk(q.size() == 0 && irq == 0, "R10 stop after disable", q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule